// File: doc/BRIEF.md
# Edge-Referenced Response Delay Timer

This block decides the exact carrier cycle on which a contactless card starts its reply. The reply is timed from the end of the reader's most recent modulation pause, not from a bit-clock grid. The demodulated reader signal `rx_level` is low while the reader pauses its carrier. A rising edge on it marks the end of a pause, and a falling edge marks the start of one.

A free-running counter on the carrier clock restarts on every edge of `rx_level`. When the frame decoder reports a good end of frame on `frame_end`, the timer is armed. At that same point it captures the logic value of the final received bit on `last_bit`, which selects one of two delays. Once the counter reaches the selected delay, the block raises `tx_start` for one cycle. On that same edge it resets and enables a carrier/`SUB_DIV` subcarrier divider, so the subcarrier phase is fixed to the start pulse.

A secondary flag `pause_seen` is set at the start of each pause. It is cleared a fixed number of cycles after the most recent edge. All pins are plain control levels or pulses. No data moves through the block, so there is no valid/ready handshake.

Top module: `resp_delay_timer`

## Requirements
- R1: The delay counter restarts on every edge of `rx_level`. When armed, `tx_start` rises on the clock edge DLY cycles after the edge that first samples `rx_level` high following a low, where DLY is the selected delay. Only the most recent end of pause counts.
- R2: The delay is chosen when `frame_end` is high. `last_bit` = 0 selects DLY_ZERO and `last_bit` = 1 selects DLY_ONE.
- R3: With no `frame_end` since the last start pulse, no `tx_start` occurs, however many pauses arrive.
- R4: `tx_start` is high for exactly one cycle, and it fires at most once per `frame_end`.
- R5: A new pause that arrives while the timer is armed but before it fires retargets the start. The start pulse then comes DLY cycles after the new end of pause, without a new `frame_end`.
- R6: On the start pulse, `sub_en` goes to 1 and `sub_clk` goes to 1 in the same cycle. From then on, `sub_clk` is high for SUB_DIV/2 cycles and low for SUB_DIV/2 cycles, repeating. While `sub_en` is 0, `sub_clk` is 0.
- R7: A falling edge of `rx_level` clears `sub_en` and `sub_clk` from the next cycle.
- R8: `pause_seen` goes to 1 on the edge that detects a falling `rx_level`. It returns to 0 on the edge MARK_DLY cycles after the most recent edge of `rx_level`. A rising edge does not set it.
- R9: The counter saturates at its maximum. A `frame_end` that arrives after the count has passed the target produces no start until the next end of pause.
- R10: After reset, `tx_start`, `sub_en`, `sub_clk` and `pause_seen` are 0, and the timer is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | 1 | Demodulated reader signal, 0 during a pause |
| frame_end | input | 1 | One-cycle pulse: valid end of frame, arms the timer |
| last_bit | input | 1 | Value of the final received bit, sampled with `frame_end` |
| tx_start | output | 1 | One-cycle transmit start pulse |
| sub_en | output | 1 | Subcarrier enabled |
| sub_clk | output | 1 | Subcarrier at clock / SUB_DIV, phase-locked to `tx_start` |
| pause_seen | output | 1 | Set at start of pause, cleared MARK_DLY cycles after the last edge |

## Verification
The bench counts sample points at negative clock edges, with sample 1 being the first falling clock edge after an input change. `tx_start` is due at sample DLY+1 after the end of pause is driven. `sub_en` and `sub_clk` drop at sample 1 after a pause begins. `pause_seen` is high from sample 1 through sample MARK_DLY, or through L+MARK_DLY when the pause ends at sample L with L no larger than MARK_DLY. Each observation window records the first sample that shows `tx_start` and compares it with that arithmetic. The bench then compares every later sample of `sub_clk` against the SUB_DIV/2 square wave.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  // Edges of the demodulated reader signal, one clock wide.
  typedef struct packed {
    logic rise;   // end of a pause
    logic fall;   // start of a pause
  } rx_edge_t;
endpackage

// File: rtl/rdt_edge_detect.sv
module rdt_edge_detect
  import rdt_pkg::*;
#(
  parameter bit IDLE_LEVEL = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_level,
  output rx_edge_t edges
);
  logic rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_q <= IDLE_LEVEL;
    else        rx_q <= rx_level;
  end

  always_comb begin
    edges.rise = rx_level & ~rx_q;
    edges.fall = ~rx_level & rx_q;
  end
endmodule

// File: rtl/rdt_delay_timer.sv
module rdt_delay_timer
  import rdt_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int DLY_ZERO = 1172,
  parameter int DLY_ONE  = 1236,
  parameter int MARK_DLY = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  rx_edge_t edges,
  input  logic     frame_end,
  input  logic     last_bit,
  output logic     fire_now,
  output logic     tx_start,
  output logic     pause_seen
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TGT_ZERO = CNT_W'(DLY_ZERO - 1);
  localparam logic [CNT_W-1:0] TGT_ONE  = CNT_W'(DLY_ONE - 1);
  localparam logic [CNT_W-1:0] MARK_END = CNT_W'(MARK_DLY - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target_m1;
  logic             armed;
  logic             any_edge;

  assign any_edge = edges.rise | edges.fall;
  assign fire_now = armed && !any_edge && (cnt == target_m1);

  // Counter referenced to the latest pause edge; saturates so a stale arm never fires.
  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (any_edge)       cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      target_m1 <= TGT_ZERO;
    end else if (frame_end) begin
      armed     <= 1'b1;
      target_m1 <= last_bit ? TGT_ONE : TGT_ZERO;
    end else if (fire_now) begin
      armed     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tx_start <= 1'b0;
    else        tx_start <= fire_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                pause_seen <= 1'b0;
    else if (edges.fall)                       pause_seen <= 1'b1;
    else if (!edges.rise && cnt == MARK_END)   pause_seen <= 1'b0;
  end

  // R3: a start pulse needs an arming that was present on the edge that raised it
  assert_start_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(armed));
  // R4: arming is consumed by the pulse, so it cannot repeat without frame_end
  assert_arm_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_now && !frame_end) |=> !armed);
  // R1: every end of pause restarts the delay measurement
  assert_count_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    edges.rise |=> (cnt == '0));
  // R8: start of a pause always raises the flag
  assert_mark_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    edges.fall |=> pause_seen);
endmodule

// File: rtl/rdt_subcarrier.sv
module rdt_subcarrier #(
  parameter int SUB_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic sub_en,
  output logic sub_clk
);
  localparam int HALF = SUB_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DW-1:0] HALF_M1 = DW'(HALF - 1);

  logic [DW-1:0] div;

  always_ff @(posedge clk) begin
    if (!rst_n || stop) begin
      sub_en  <= 1'b0;
      sub_clk <= 1'b0;
      div     <= '0;
    end else if (start) begin
      sub_en  <= 1'b1;
      sub_clk <= 1'b1;
      div     <= '0;
    end else if (sub_en) begin
      if (div == HALF_M1) begin
        div     <= '0;
        sub_clk <= ~sub_clk;
      end else begin
        div     <= div + 1'b1;
      end
    end
  end

  // R6: an idle divider keeps its output low
  assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_en |-> !sub_clk);
  // R7: a pause shuts the subcarrier off on the next cycle
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!sub_en && !sub_clk));
endmodule

// File: rtl/resp_delay_timer.sv
module resp_delay_timer
  import rdt_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int DLY_ZERO = 1172,
  parameter int DLY_ONE  = 1236,
  parameter int MARK_DLY = 32,
  parameter int SUB_DIV  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_level,
  input  logic frame_end,
  input  logic last_bit,
  output logic tx_start,
  output logic sub_en,
  output logic sub_clk,
  output logic pause_seen
);
  rx_edge_t edges;
  logic     fire_now;

  rdt_edge_detect #(.IDLE_LEVEL(1'b1)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_level (rx_level),
    .edges    (edges)
  );

  rdt_delay_timer #(
    .CNT_W    (CNT_W),
    .DLY_ZERO (DLY_ZERO),
    .DLY_ONE  (DLY_ONE),
    .MARK_DLY (MARK_DLY)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .edges      (edges),
    .frame_end  (frame_end),
    .last_bit   (last_bit),
    .fire_now   (fire_now),
    .tx_start   (tx_start),
    .pause_seen (pause_seen)
  );

  rdt_subcarrier #(.SUB_DIV(SUB_DIV)) u_sub (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (fire_now),
    .stop    (edges.fall),
    .sub_en  (sub_en),
    .sub_clk (sub_clk)
  );

  // R6: subcarrier phase is pinned to the start pulse
  assert_sub_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (sub_en && sub_clk));
  // R4: start pulse is one cycle wide
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
endmodule

// File: tb/resp_delay_timer_test.sv
`timescale 1ns/1ps
module resp_delay_timer_test;
  localparam int CW = 8;
  localparam int D0 = 40;
  localparam int D1 = 56;
  localparam int MK = 12;
  localparam int SD = 16;
  localparam int HALF = SD / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_level = 1'b1;
  logic frame_end = 1'b0;
  logic last_bit = 1'b0;
  logic tx_start, sub_en, sub_clk, pause_seen;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  resp_delay_timer #(
    .CNT_W(CW), .DLY_ZERO(D0), .DLY_ONE(D1), .MARK_DLY(MK), .SUB_DIV(SD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .frame_end(frame_end),
    .last_bit(last_bit), .tx_start(tx_start), .sub_en(sub_en),
    .sub_clk(sub_clk), .pause_seen(pause_seen)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pause of len samples, then end of pause with optional arming. Returns at sample 1.
  task automatic pause_then_rise(input int len, input bit arm, input bit b);
    rx_level = 1'b0;
    @(negedge clk);
    check(!sub_en && !sub_clk, "R7 subcarrier off after pause", {sub_en, sub_clk}, 0);
    repeat (len - 1) @(negedge clk);
    rx_level  = 1'b1;
    frame_end = arm;
    last_bit  = b;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic observe(input int win, output int first, output int ones, output int bad);
    first = -1; ones = 0; bad = 0;
    for (int s = 1; s <= win; s++) begin
      if (s > 1) @(negedge clk);
      if (tx_start) begin
        if (first < 0) first = s;
        ones++;
      end
      if (first < 0) begin
        if (sub_en || sub_clk) bad++;
      end else begin
        if (!sub_en || (sub_clk != (((s - first) / HALF) % 2 == 0))) bad++;
      end
    end
  endtask

  int first, ones, bad;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_start, "R10 tx_start after reset", tx_start, 0);
    check(!sub_en, "R10 sub_en after reset", sub_en, 0);
    check(!sub_clk, "R10 sub_clk after reset", sub_clk, 0);
    check(!pause_seen, "R10 pause_seen after reset", pause_seen, 0);
    observe(D1 + 10, first, ones, bad);
    check(first < 0, "R10 not armed after reset", first, -1);

    // R1 R2 R4 R6: delay selection and subcarrier shape over pause lengths
    for (int b = 0; b < 2; b++) begin
      foreach (lens[i]) begin
        pause_then_rise(lens[i], 1'b1, b[0]);
        observe(D1 + 40, first, ones, bad);
        check(first == (b ? D1 : D0) + 1, b ? "R2 delay after final 1" : "R1 delay after final 0",
              first, (b ? D1 : D0) + 1);
        check(ones == 1, "R4 single pulse", ones, 1);
        check(bad == 0, "R6 subcarrier pattern", bad, 0);
      end
    end

    // R3: end of pause without arming
    pause_then_rise(3, 1'b0, 1'b0);
    observe(D1 + 20, first, ones, bad);
    check(first < 0, "R3 no start without frame_end", first, -1);

    // R4: once per arming
    pause_then_rise(2, 1'b1, 1'b1);
    observe(D1 + 5, first, ones, bad);
    check(first == D1 + 1, "R4 armed start", first, D1 + 1);
    pause_then_rise(3, 1'b0, 1'b1);
    observe(D1 + 20, first, ones, bad);
    check(ones == 0, "R4 no second start", ones, 0);

    // R5: retarget on a new pause before expiry
    foreach (waits[i]) begin
      pause_then_rise(2, 1'b1, 1'b0);
      repeat (waits[i]) @(negedge clk);
      pause_then_rise(2, 1'b0, 1'b0);
      observe(D0 + 20, first, ones, bad);
      check(first == D0 + 1, "R5 retargeted start", first, D0 + 1);
      check(ones == 1, "R5 single retargeted pulse", ones, 1);
    end

    // R9: arming after the count has saturated past the target
    pause_then_rise(2, 1'b0, 1'b0);
    repeat (300) @(negedge clk);
    frame_end = 1'b1;
    last_bit  = 1'b0;
    @(negedge clk);
    frame_end = 1'b0;
    observe(D0 + 30, first, ones, bad);
    check(first < 0, "R9 stale arming does not fire", first, -1);
    pause_then_rise(2, 1'b0, 1'b0);
    observe(D0 + 10, first, ones, bad);
    check(first == D0 + 1, "R9 fires after next end of pause", first, D0 + 1);

    // R8: pause flag timing over pause lengths
    for (int len = 1; len <= MK + 3; len++) begin
      int last_hi;
      int mism;
      repeat (MK + 4) @(negedge clk);
      last_hi = (len <= MK) ? len + MK : MK;
      mism = 0;
      rx_level = 1'b0;
      for (int s = 1; s <= len + MK + 4; s++) begin
        @(negedge clk);
        if (pause_seen != (s <= last_hi)) mism++;
        if (s == len) rx_level = 1'b1;
      end
      check(mism == 0, "R8 pause_seen window", mism, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int lens[5] = '{1, 2, 3, 5, 8};
  int waits[3] = '{4, 20, 35};

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule